// File: doc/BRIEF.md
# Auto-Incrementing Register Pointer Bank

This block sits behind the byte-level engine of a two-wire serial slave. It holds an 8-bit byte pointer and a bank of 10-bit control registers. Each register takes two byte addresses: the even address holds bits 7:0 and the odd address holds bits 9:8. The protocol engine reports an address match together with the direction bit. It then reports each received byte, each read byte the master has taken, and the stop condition.

In a write transaction, the first byte loads the pointer. Every later byte is stored at the pointer. In a read transaction, bytes come out starting at the pointer left by an earlier write transaction. The pointer advances by one after every data byte in either direction. It stops at the last byte address, 0x25, and the block keeps acknowledging further write bytes there. The read byte is a combinational function of the current pointer. It is therefore ready whenever the engine asks for it. All register contents are brought out in parallel.

Top module: `regptr_bank`

## Requirements
- R1: After reset, the pointer is 0x00, every register is zero, rd_data_o is 0x00 and wr_ack_o is low.
- R2: In a write transaction (adr_hit_i with adr_rw_i=0), the first byte on wr_vld_i is acknowledged and loads the pointer. A value above 0x25 loads as 0x25.
- R3: A later write byte at an even pointer replaces bits 7:0 of register pointer>>1. At an odd pointer, only byte bits 1:0 go into register bits 9:8. The other bits of the register keep their value.
- R4: The pointer increases by one after each acknowledged write data byte, and after each rd_done_i in a read transaction (adr_hit_i with adr_rw_i=1).
- R5: At pointer 0x25 the pointer holds for further data bytes. Write bytes there are still acknowledged and still update bits 9:8 of the last register.
- R6: rd_data_o shows, in the same cycle, bits 7:0 of register pointer>>1 for an even pointer. For an odd pointer it shows bits 9:8 with six zero bits above them.
- R7: A read transaction starts at the pointer left by the previous write transaction. The address match does not move the pointer, and reads never change a register.
- R8: Bytes and read strobes outside a transaction of the matching direction are ignored. This covers the time before any match, after stop_i, write bytes during a read, and rd_done_i during a write. An ignored strobe gives no acknowledge and leaves the pointer and the registers unchanged.
- R9: A repeated address match without a stop starts a new transaction. With adr_rw_i=0, the next byte loads the pointer again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adr_hit_i | input | 1 | One-cycle strobe: slave address matched |
| adr_rw_i | input | 1 | Direction with adr_hit_i: 1 = read, 0 = write |
| stop_i | input | 1 | One-cycle strobe: bus stop seen |
| wr_vld_i | input | 1 | One-cycle strobe: byte received from master |
| wr_data_i | input | 8 | Received byte |
| rd_done_i | input | 1 | One-cycle strobe: read byte transferred to master |
| wr_ack_o | output | 1 | Combinational: the current received byte is acknowledged |
| rd_data_o | output | 8 | Byte at the current pointer |
| ptr_o | output | 8 | Current byte pointer |
| regs_o | output | 190 | All registers; register i occupies bits 10*i+9 down to 10*i |

## Verification
wr_ack_o and rd_data_o are combinational. The bench therefore samples them 1 ns after driving the inputs, within the same cycle as the strobe. Pointer and register updates take effect at the rising edge that captures a strobe. The bench drives each strobe at a falling edge and checks ptr_o and regs_o at the next falling edge, one edge later. Reads are swept from every start address up to saturation, and the expected bytes come from an arithmetic model of the write pattern.

// File: rtl/regptr_pkg.sv
package regptr_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_PTR   = 2'd1,
    TX_WDATA = 2'd2,
    TX_RDATA = 2'd3
  } txn_e;
endpackage

// File: rtl/regptr_txn_fsm.sv
module regptr_txn_fsm
  import regptr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adr_hit_i,
  input  logic adr_rw_i,
  input  logic stop_i,
  input  logic wr_vld_i,
  input  logic rd_done_i,
  output logic ptr_load_o,
  output logic data_wr_o,
  output logic rd_adv_o,
  output logic wr_ack_o
);
  txn_e st_q, st_d;
  logic qual;

  // A new match or a stop overrides any byte strobe in the same cycle.
  assign qual       = !adr_hit_i && !stop_i;
  assign ptr_load_o = qual && wr_vld_i  && (st_q == TX_PTR);
  assign data_wr_o  = qual && wr_vld_i  && (st_q == TX_WDATA);
  assign rd_adv_o   = qual && rd_done_i && (st_q == TX_RDATA);
  assign wr_ack_o   = ptr_load_o || data_wr_o;

  always_comb begin
    st_d = st_q;
    if (adr_hit_i) begin
      st_d = adr_rw_i ? TX_RDATA : TX_PTR;
    end else if (stop_i) begin
      st_d = TX_IDLE;
    end else if (ptr_load_o) begin
      st_d = TX_WDATA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TX_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/regptr_pointer.sv
module regptr_pointer #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(2*NUM_REGS-1);

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              ptr_en;

  assign ptr_en = load_i || (adv_i && (ptr_q < LAST));

  always_comb begin
    ptr_d = ptr_q;
    if (load_i) begin
      ptr_d = (load_val_i > LAST) ? LAST : load_val_i;
    end else if (adv_i && (ptr_q < LAST)) begin
      ptr_d = ptr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/regptr_regfile.sv
module regptr_regfile #(
  parameter int ADDR_W   = 8,
  parameter int REG_W    = 10,
  parameter int NUM_REGS = 19
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [7:0]                wdata_i,
  output logic [7:0]                rdata_o,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  localparam int HI_W = REG_W - 8;
  localparam int IX_W = ADDR_W - 1;

  logic [REG_W-1:0] reg_q [NUM_REGS];
  logic [IX_W-1:0]  idx;
  logic             upper;

  assign idx   = addr_i[ADDR_W-1:1];
  assign upper = addr_i[0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic             sel, lo_en, hi_en;
    logic [7:0]       lo_d;
    logic [HI_W-1:0]  hi_d;

    assign sel   = wr_i && (idx == IX_W'(g));
    assign lo_en = sel && !upper;
    assign hi_en = sel && upper;

    always_comb begin
      lo_d = reg_q[g][7:0];
      hi_d = reg_q[g][REG_W-1:8];
      if (lo_en) lo_d = wdata_i;
      if (hi_en) hi_d = wdata_i[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[g] <= '0;
      end else begin
        if (lo_en) reg_q[g][7:0]       <= lo_d;
        if (hi_en) reg_q[g][REG_W-1:8] <= hi_d;
      end
    end

    assign regs_o[g*REG_W +: REG_W] = reg_q[g];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IX_W'(i)) begin
        rdata_o = upper ? {{(8-HI_W){1'b0}}, reg_q[i][REG_W-1:8]} : reg_q[i][7:0];
      end
    end
  end
endmodule

// File: rtl/regptr_bank.sv
module regptr_bank #(
  parameter int ADDR_W   = 8,
  parameter int REG_W    = 10,
  parameter int NUM_REGS = 19
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      adr_hit_i,
  input  logic                      adr_rw_i,
  input  logic                      stop_i,
  input  logic                      wr_vld_i,
  input  logic [7:0]                wr_data_i,
  input  logic                      rd_done_i,
  output logic                      wr_ack_o,
  output logic [7:0]                rd_data_o,
  output logic [ADDR_W-1:0]         ptr_o,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  logic ptr_load, data_wr, rd_adv;

  regptr_txn_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .adr_hit_i  (adr_hit_i),
    .adr_rw_i   (adr_rw_i),
    .stop_i     (stop_i),
    .wr_vld_i   (wr_vld_i),
    .rd_done_i  (rd_done_i),
    .ptr_load_o (ptr_load),
    .data_wr_o  (data_wr),
    .rd_adv_o   (rd_adv),
    .wr_ack_o   (wr_ack_o)
  );

  regptr_pointer #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ptr_load),
    .load_val_i (ADDR_W'(wr_data_i)),
    .adv_i      (data_wr || rd_adv),
    .ptr_o      (ptr_o)
  );

  regptr_regfile #(.ADDR_W(ADDR_W), .REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (data_wr),
    .addr_i  (ptr_o),
    .wdata_i (wr_data_i),
    .rdata_o (rd_data_o),
    .regs_o  (regs_o)
  );
endmodule

// File: rtl/regptr_bank_chk.sv
module regptr_bank_chk #(
  parameter int ADDR_W   = 8,
  parameter int REG_W    = 10,
  parameter int NUM_REGS = 19
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      adr_hit_i,
  input logic                      stop_i,
  input logic                      wr_vld_i,
  input logic                      rd_done_i,
  input logic                      wr_ack_o,
  input logic [7:0]                rd_data_o,
  input logic [ADDR_W-1:0]         ptr_o,
  input logic [NUM_REGS*REG_W-1:0] regs_o
);
  localparam int HI_W = REG_W - 8;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(2*NUM_REGS-1);

  // R5: pointer never leaves the mapped range
  a_r5_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_o <= LAST);

  // R8: without an acknowledged byte or a read strobe the pointer holds
  a_r8_ptr_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ack_o && !rd_done_i) |=> $stable(ptr_o));

  // R7: registers change only on an acknowledged write byte
  a_r7_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ack_o |=> $stable(regs_o));

  // R8: acknowledge only while a byte is offered
  a_r8_ack_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack_o |-> wr_vld_i);

  // R5: a read strobe at the last address leaves the pointer there
  a_r5_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_o == LAST && rd_done_i && !wr_vld_i && !adr_hit_i && !stop_i) |=> ptr_o == LAST);

  // R4: a read strobe moves the pointer by at most one
  a_r4_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done_i && !wr_vld_i && ptr_o < LAST) |=>
      (ptr_o == $past(ptr_o) || ptr_o == $past(ptr_o) + ADDR_W'(1)));

  // R6: the upper half reads back zero-extended
  a_r6_upper_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_o[0] |-> rd_data_o[7:HI_W] == '0);
endmodule

bind regptr_bank regptr_bank_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W), .NUM_REGS(NUM_REGS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .adr_hit_i (adr_hit_i),
  .stop_i    (stop_i),
  .wr_vld_i  (wr_vld_i),
  .rd_done_i (rd_done_i),
  .wr_ack_o  (wr_ack_o),
  .rd_data_o (rd_data_o),
  .ptr_o     (ptr_o),
  .regs_o    (regs_o)
);

// File: tb/regptr_bank_tb_top.sv
`timescale 1ns/1ps
module regptr_bank_tb_top;
  localparam int NR   = 19;
  localparam int RW   = 10;
  localparam int LAST = 2*NR - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adr_hit_i = 1'b0, adr_rw_i = 1'b0, stop_i = 1'b0, wr_vld_i = 1'b0, rd_done_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic wr_ack_o;
  logic [7:0] rd_data_o, ptr_o;
  logic [NR*RW-1:0] regs_o;

  int errors = 0, checks = 0;
  int m_lo [NR];
  int m_hi [NR];
  int m_ptr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  regptr_bank dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rd(input int p);
    return p[0] ? m_hi[p >> 1] : m_lo[p >> 1];
  endfunction

  task automatic chk_regs(input string tag);
    for (int i = 0; i < NR; i++) begin
      int e = m_hi[i] * 256 + m_lo[i];
      int a = int'(regs_o[i*RW +: RW]);
      chk(a == e, tag, a, e);
    end
  endtask

  task automatic start(input bit rw);
    @(negedge clk); adr_hit_i = 1'b1; adr_rw_i = rw;
    @(negedge clk); adr_hit_i = 1'b0;
  endtask

  task automatic stop();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
  endtask

  // mode: 0 ignored, 1 pointer load, 2 data byte
  task automatic wbyte(input int b, input int mode, input string tag);
    @(negedge clk); wr_vld_i = 1'b1; wr_data_i = 8'(b);
    #1 chk(wr_ack_o == (mode != 0), tag, int'(wr_ack_o), int'(mode != 0));
    @(negedge clk); wr_vld_i = 1'b0;
    if (mode == 1) m_ptr = (b > LAST) ? LAST : b;
    if (mode == 2) begin
      if (m_ptr[0]) m_hi[m_ptr >> 1] = b % 4;
      else          m_lo[m_ptr >> 1] = b;
      if (m_ptr < LAST) m_ptr++;
    end
    chk(int'(ptr_o) == m_ptr, tag, int'(ptr_o), m_ptr);
  endtask

  task automatic rbyte(input bit active, input string tag);
    @(negedge clk);
    #1 chk(int'(rd_data_o) == exp_rd(m_ptr), "R6", int'(rd_data_o), exp_rd(m_ptr));
    rd_done_i = 1'b1;
    @(negedge clk); rd_done_i = 1'b0;
    if (active && m_ptr < LAST) m_ptr++;
    chk(int'(ptr_o) == m_ptr, tag, int'(ptr_o), m_ptr);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ptr_o == 8'h00, "R1", int'(ptr_o), 0);
    chk(rd_data_o == 8'h00, "R1", int'(rd_data_o), 0);
    chk(wr_ack_o == 1'b0, "R1", int'(wr_ack_o), 0);
    chk_regs("R1");

    // R8: bytes before any address match
    wbyte(8'h55, 0, "R8");
    rbyte(0, "R8");
    chk_regs("R8");

    // R2/R3/R5: full burst from 0 with extra bytes beyond the last address
    start(0);
    wbyte(0, 1, "R2");
    for (int a = 0; a <= LAST + 3; a++) begin
      wbyte((a * 37 + 11) % 256, 2, (a >= LAST) ? "R5" : "R4");
      if (a == 2 || a == 3) chk_regs("R3");
    end
    chk(int'(ptr_o) == LAST, "R5", int'(ptr_o), LAST);
    stop();
    chk_regs("R3");

    // R8: after stop a byte is ignored
    wbyte(8'h3C, 0, "R8");
    chk_regs("R8");

    // R4/R6/R7: read sweep from every start address
    for (int s = 0; s <= LAST; s++) begin
      start(0);
      wbyte(s, 1, "R2");
      stop();
      start(1);
      chk(int'(ptr_o) == s, "R7", int'(ptr_o), s);
      if (s == 5) begin
        wbyte(8'hAA, 0, "R8");
        chk_regs("R8");
      end
      for (int k = s; k <= LAST + 1; k++) rbyte(1, "R4");
      stop();
    end
    chk_regs("R7");

    // R2: out-of-range pointer value clamps to the last address
    start(0);
    wbyte(8'hF0, 1, "R2");
    rbyte(0, "R8");
    stop();

    // R9: read, then repeated match into write without stop
    start(1);
    rbyte(1, "R4");
    start(0);
    wbyte(4, 1, "R9");
    wbyte(8'hA5, 2, "R9");
    wbyte(8'hFE, 2, "R3");
    chk_regs("R9");
    start(1);
    chk(int'(ptr_o) == 6, "R9", int'(ptr_o), 6);
    stop();
    start(0);
    wbyte(5, 1, "R2");
    stop();
    start(1);
    rbyte(1, "R6");
    stop();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule